// File: doc/BRIEF.md
# Voice trigger request controller

This block sits between the trigger pins of a voice playback device and its playback engine. It converts key presses, a sequential button and a parallel address strobe into start and stop requests for up to 254 voice groups. Two mode pins pick between key mode and parallel mode. The other two codes switch triggering off. All trigger inputs go through one debouncer. The debouncer counts ticks of a timebase-enable input, so its lengths follow the sampling rate.

Each voice group has three options of its own. They are edge or level trigger, holdable or unholdable, and retriggerable or not. Together they decide how a press starts, holds, stops or restarts playback. The playback engine is represented only by a one-cycle start pulse with a group number, a one-cycle stop pulse, and a finished pulse it returns. A ramp-down completion input opens a hold-off window in which new triggers are refused.

Top module: `voice_trig_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `play_start` and `play_stop` are 0, and `play_group` is 0.
- R2: When `mode` is 2'b10 or 2'b11, no input pattern produces `play_start`.
- R3: In key mode (`mode` = 2'b00), a debounced nonzero key pattern equal to entry i of `KEY_MAP` starts group i+1. With the default map, entry i holds the value i+1, so patterns 1 to 32 start the group of the same number. Other patterns start nothing.
- R4: In key mode, each accepted rise of `btn` starts the next group of the walk 33, 34, ..., 254, after which the walk returns to 33. A rise that is refused does not advance the walk.
- R5: In parallel mode (`mode` = 2'b01), a debounced rise of `btn` starts group `keys`+1. Here `keys[7]` is the MSB. Addresses 8'hFE and 8'hFF are ignored, and a change of `keys` without a strobe starts nothing.
- R6: An input change is accepted only after it has held stable for the debounce count of ticks. That count is `DB_SHORT` when `long_db` is 0 and `DB_LONG` when it is 1. The start pulse appears at the count plus 2 clock edges after the change (with `tick` held high).
- R7: While a retriggerable group is playing, the debounce count becomes `DB_SHORT_RT` or `DB_LONG_RT`.
- R8: For `HOLDOFF` ticks after a `ramp_done` pulse, every trigger is refused. A trigger accepted during that window does not take effect later.
- R9: For a level, holdable group, release of its trigger pattern emits `play_stop` and clears `busy`.
- R10: For a level, unholdable group, release has no effect. When `play_done` arrives, the same group restarts if its pattern is still held; otherwise `busy` falls.
- R11: An edge group never restarts on `play_done`. A new press while an edge, holdable group plays emits `play_stop`, and this takes precedence over its retrigger option.
- R12: A press while a retriggerable group plays starts the requested group at once. A press while a non-retriggerable group plays is ignored.
- R13: A press accepted in the same cycle as `play_done` is treated as a press while idle, and starts its group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 key mode, 01 parallel mode, 10/11 triggering off |
| keys | input | 8 | Key pattern (key mode) or group address (parallel mode) |
| btn | input | 1 | Sequential button (key mode) or address strobe (parallel mode) |
| tick | input | 1 | Timebase enable that advances debounce and hold-off counts |
| long_db | input | 1 | Selects the long debounce counts |
| ramp_done | input | 1 | Pulse marking the end of a ramp-down |
| play_done | input | 1 | Pulse from the engine: current group finished |
| play_start | output | 1 | Pulse: start or restart `play_group` |
| play_stop | output | 1 | Pulse: stop the current playback |
| play_group | output | 8 | Group number (1 to 254) of the current request |
| busy | output | 1 | A group is playing |

## Verification
The sharpest collision happens when the engine's finished pulse lands in the very cycle that a debounced press is accepted. In that cycle the block must choose between refusing the press (non-retriggerable group still playing), looping the old group and starting the new one. The bench provokes this by placing `play_done` exactly on the accepting edge, derived from the debounce count. It then expects a start of the newly pressed group and nothing else. A second overlap joins the ramp hold-off to a press that settles inside it. For that case the bench requires silence across the window and a normal start once the window has closed.

// File: rtl/voice_trig_ctrl.sv
module voice_trig_ctrl #(
  parameter int DB_SHORT    = 4,
  parameter int DB_LONG     = 128,
  parameter int DB_SHORT_RT = 12,
  parameter int DB_LONG_RT  = 192,
  parameter int HOLDOFF     = 256,
  parameter int SEQ_FIRST   = 33,
  parameter int SEQ_LAST    = 254,
  parameter int NKEY        = 32,
  parameter logic [NKEY*8-1:0] KEY_MAP =
    256'h201F1E1D1C1B1A191817161514131211100F0E0D0C0B0A090807060504030201,
  parameter logic [255:0] GRP_EDGE   = '0,
  parameter logic [255:0] GRP_HOLD   = '0,
  parameter logic [255:0] GRP_RETRIG = '0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [7:0] keys,
  input  logic       btn,
  input  logic       tick,
  input  logic       long_db,
  input  logic       ramp_done,
  input  logic       play_done,
  output logic       play_start,
  output logic       play_stop,
  output logic [7:0] play_group,
  output logic       busy
);
  localparam int DB_A   = (DB_LONG > DB_SHORT) ? DB_LONG : DB_SHORT;
  localparam int DB_B   = (DB_LONG_RT > DB_SHORT_RT) ? DB_LONG_RT : DB_SHORT_RT;
  localparam int DB_MAX = (DB_A > DB_B) ? DB_A : DB_B;
  localparam int CW     = $clog2(DB_MAX + 1);
  localparam int HW     = $clog2(HOLDOFF + 1);

  logic [8:0]    raw, cand, deb;
  logic [CW-1:0] cnt, thr;
  logic [HW-1:0] ho_cnt;
  logic [7:0]    cur_grp, cur_code, seq_ptr, key_idx, req_grp, sgrp, s_code;
  logic          cur_btn, s_btn, key_hit, rt, accept, blocked;
  logic          key_press, seq_press, par_press, req_ok, held;
  logic          start, stop, adv;

  wire key_mode = (mode == 2'b00);
  wire par_mode = (mode == 2'b01);
  wire mode_on  = key_mode | par_mode;
  wire c_edge   = GRP_EDGE[cur_grp];
  wire c_hold   = GRP_HOLD[cur_grp];
  wire c_retrig = GRP_RETRIG[cur_grp];
  wire active   = busy & ~play_done;

  assign raw        = {btn, keys};
  assign rt         = busy & c_retrig;
  assign thr        = long_db ? (rt ? CW'(DB_LONG_RT)  : CW'(DB_LONG))
                              : (rt ? CW'(DB_SHORT_RT) : CW'(DB_SHORT));
  assign accept     = (raw == cand) && (cnt >= thr) && (deb != cand);
  assign blocked    = ramp_done | (ho_cnt != '0);
  assign play_group = cur_grp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand <= '0;
      cnt  <= '0;
      deb  <= '0;
    end else if (raw != cand) begin
      cand <= raw;
      cnt  <= '0;
    end else begin
      if (tick && cnt < thr) cnt <= cnt + 1'b1;
      if (accept) deb <= cand;
    end
  end

  always_comb begin
    key_hit = 1'b0;
    key_idx = '0;
    for (int i = NKEY - 1; i >= 0; i--) begin
      if (cand[7:0] != 8'd0 && KEY_MAP[i*8 +: 8] == cand[7:0]) begin
        key_hit = 1'b1;
        key_idx = 8'(i);
      end
    end
  end

  assign key_press = key_mode & accept & (cand[7:0] != deb[7:0]) & key_hit;
  assign seq_press = key_mode & accept & cand[8] & ~deb[8] & ~key_press;
  assign par_press = par_mode & accept & cand[8] & ~deb[8] & (cand[7:0] <= 8'hFD);
  assign req_ok    = (key_press | seq_press | par_press) & ~blocked;
  assign req_grp   = key_press ? key_idx + 8'd1 :
                     seq_press ? seq_ptr : cand[7:0] + 8'd1;
  assign held      = cur_btn ? deb[8] : (deb[7:0] == cur_code);

  always_comb begin
    start  = 1'b0;
    stop   = 1'b0;
    adv    = 1'b0;
    sgrp   = cur_grp;
    s_btn  = cur_btn;
    s_code = cur_code;
    if (active && req_ok && c_edge && c_hold) begin
      stop = 1'b1;
    end else if (req_ok && (!active || c_retrig)) begin
      start  = 1'b1;
      sgrp   = req_grp;
      s_btn  = ~key_press;
      s_code = cand[7:0];
      adv    = seq_press;
    end else if (active && !c_edge && c_hold && !held) begin
      stop = 1'b1;
    end else if (busy && play_done && !c_edge && held && mode_on && !blocked) begin
      start = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      play_start <= 1'b0;
      play_stop  <= 1'b0;
      busy       <= 1'b0;
      cur_grp    <= '0;
      cur_code   <= '0;
      cur_btn    <= 1'b0;
      seq_ptr    <= 8'(SEQ_FIRST);
      ho_cnt     <= '0;
    end else begin
      play_start <= start;
      play_stop  <= stop;
      if (start) begin
        busy     <= 1'b1;
        cur_grp  <= sgrp;
        cur_btn  <= s_btn;
        cur_code <= s_code;
      end else if (stop || play_done) begin
        busy <= 1'b0;
      end
      if (adv) seq_ptr <= (seq_ptr == 8'(SEQ_LAST)) ? 8'(SEQ_FIRST) : seq_ptr + 8'd1;
      if (ramp_done) ho_cnt <= HW'(HOLDOFF);
      else if (tick && ho_cnt != '0) ho_cnt <= ho_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/voice_trig_ctrl_chk.sv
module voice_trig_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       ramp_done,
  input logic       play_start,
  input logic       play_stop,
  input logic [7:0] play_group,
  input logic       busy
);
  p_off_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> !play_start);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |-> busy);

  p_group_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    play_start |-> (play_group >= 8'd1 && play_group <= 8'd254));

  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_done |=> !play_start);

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    play_stop |-> !busy && $past(busy));

  p_start_stop_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(play_start && play_stop));
endmodule

bind voice_trig_ctrl voice_trig_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ramp_done(ramp_done),
  .play_start(play_start), .play_stop(play_stop),
  .play_group(play_group), .busy(busy)
);

// File: tb/voice_trig_ctrl_test.sv
module voice_trig_ctrl_test;
  localparam int PERIOD = 10;
  localparam int DBS = 3, DBL = 8, DBSR = 6, DBLR = 12, HOLD = 20;
  localparam logic [255:0] T_EDGE   = (256'd1 << 3) | (256'd1 << 4) | (256'd1 << 6) | (256'd1 << 34);
  localparam logic [255:0] T_HOLD   = (256'd1 << 2) | (256'd1 << 4);
  localparam logic [255:0] T_RETRIG = (256'd1 << 5) | (256'd1 << 6);

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'b00;
  logic [7:0] keys = 0;
  logic btn = 0, tick = 1, long_db = 0, ramp_done = 0, play_done = 0;
  logic play_start, play_stop, busy;
  logic [7:0] play_group;

  always #(PERIOD/2) clk = ~clk;

  voice_trig_ctrl #(
    .DB_SHORT(DBS), .DB_LONG(DBL), .DB_SHORT_RT(DBSR), .DB_LONG_RT(DBLR),
    .HOLDOFF(HOLD), .GRP_EDGE(T_EDGE), .GRP_HOLD(T_HOLD), .GRP_RETRIG(T_RETRIG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .keys(keys), .btn(btn), .tick(tick),
    .long_db(long_db), .ramp_done(ramp_done), .play_done(play_done),
    .play_start(play_start), .play_stop(play_stop), .play_group(play_group), .busy(busy)
  );

  int n_chk = 0, n_bad = 0;
  bit q_stop[$];
  int q_grp[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void expect_ev(input bit s, input int g, input string tag);
    q_stop.push_back(s);
    q_grp.push_back(g);
    q_tag.push_back(tag);
  endfunction

  always @(negedge clk) begin
    if (rst_n && (play_start || play_stop)) begin
      if (q_grp.size() == 0) begin
        check(1'b0, "unexpected event (R2/R12)", play_stop * 256 + play_group, -1);
      end else begin
        automatic bit es = q_stop.pop_front();
        automatic int eg = q_grp.pop_front();
        automatic string et = q_tag.pop_front();
        check(play_stop == es && play_start == !es && play_group == eg, et,
              play_stop * 256 + play_group, es * 256 + eg);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check(q_grp.size() == 0, tag, q_grp.size(), 0);
    q_stop.delete();
    q_grp.delete();
    q_tag.delete();
  endtask

  task automatic done_pulse();
    play_done = 1;
    cyc(1);
    play_done = 0;
    cyc(2);
  endtask

  task automatic btn_pulse();
    btn = 1;
    cyc(8);
    btn = 0;
    cyc(8);
  endtask

  task automatic set_keys(input logic [7:0] k);
    keys = k;
    cyc(12);
  endtask

  task automatic measure(input logic [7:0] k, output int n);
    keys = k;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!play_start && n < 100);
  endtask

  bit finished = 0;

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    check(busy == 0 && play_start == 0 && play_stop == 0, "R1 reset outputs", busy, 0);
    check(play_group == 0, "R1 reset group", play_group, 0);
    rst_n = 1;
    cyc(5);

    // R3 + R10: level unholdable, release ignored
    expect_ev(0, 1, "R3 key pattern 1");
    set_keys(8'd1);
    check(busy == 1, "R3 busy after start", busy, 1);
    set_keys(8'd0);
    check(busy == 1, "R10 release ignored", busy, 1);
    done_pulse();
    check(busy == 0, "R10 done while released", busy, 0);
    drained("R3 queue");

    // R10 loop while held
    expect_ev(0, 1, "R10 first start");
    set_keys(8'd1);
    expect_ev(0, 1, "R10 loop restart");
    done_pulse();
    check(busy == 1, "R10 still busy", busy, 1);
    set_keys(8'd0);
    done_pulse();
    check(busy == 0, "R10 idle", busy, 0);
    drained("R10 queue");

    // R9 level holdable
    expect_ev(0, 2, "R9 start group 2");
    set_keys(8'd2);
    expect_ev(1, 2, "R9 stop on release");
    set_keys(8'd0);
    check(busy == 0, "R9 busy cleared", busy, 0);
    drained("R9 queue");

    // R11 edge unholdable: no loop
    expect_ev(0, 3, "R11 start group 3");
    set_keys(8'd3);
    done_pulse();
    check(busy == 0, "R11 edge no restart", busy, 0);
    set_keys(8'd0);
    drained("R11 queue a");

    // R11 edge holdable: second press stops
    expect_ev(0, 4, "R11 start group 4");
    set_keys(8'd4);
    set_keys(8'd0);
    check(busy == 1, "R11 edge ignores release", busy, 1);
    expect_ev(1, 4, "R11 press stops edge hold");
    set_keys(8'd4);
    check(busy == 0, "R11 stopped", busy, 0);
    set_keys(8'd0);
    drained("R11 queue b");

    // R12 retrigger, then non-retrigger ignore
    expect_ev(0, 5, "R12 start group 5");
    set_keys(8'd5);
    set_keys(8'd0);
    expect_ev(0, 1, "R12 retrigger to group 1");
    set_keys(8'd1);
    set_keys(8'd0);
    set_keys(8'd3);
    check(play_group == 1, "R12 non-retrig ignores press", play_group, 1);
    drained("R12 queue");
    set_keys(8'd0);
    done_pulse();
    check(busy == 0, "R12 idle", busy, 0);

    // R3 unmatched pattern
    set_keys(8'h80);
    check(busy == 0, "R3 unmatched pattern", busy, 0);
    set_keys(8'd0);
    drained("R3 unmatched queue");

    // R6 short debounce latency
    expect_ev(0, 1, "R6 short start");
    measure(8'd1, n);
    check(n == DBS + 2, "R6 short debounce", n, DBS + 2);
    set_keys(8'd0);
    done_pulse();

    // R7 extended debounce while retriggerable plays
    expect_ev(0, 5, "R7 start group 5");
    set_keys(8'd5);
    set_keys(8'd0);
    expect_ev(0, 1, "R7 retrigger start");
    measure(8'd1, n);
    check(n == DBSR + 2, "R7 retrigger debounce", n, DBSR + 2);
    set_keys(8'd0);
    done_pulse();

    // R6 long debounce
    long_db = 1;
    cyc(2);
    expect_ev(0, 1, "R6 long start");
    measure(8'd1, n);
    check(n == DBL + 2, "R6 long debounce", n, DBL + 2);
    set_keys(8'd0);
    done_pulse();
    long_db = 0;
    drained("R6 queue");

    // R8 hold-off after ramp-down
    ramp_done = 1;
    cyc(1);
    ramp_done = 0;
    keys = 8'd1;
    cyc(30);
    check(busy == 0, "R8 press in hold-off refused", busy, 0);
    drained("R8 queue a");
    set_keys(8'd0);
    expect_ev(0, 1, "R8 press after hold-off");
    set_keys(8'd1);
    check(busy == 1, "R8 busy after window", busy, 1);
    set_keys(8'd0);
    done_pulse();
    drained("R8 queue b");

    // R13 press lands in the play_done cycle
    expect_ev(0, 1, "R13 setup start");
    set_keys(8'd1);
    set_keys(8'd0);
    keys = 8'd3;
    cyc(DBS + 1);
    expect_ev(0, 3, "R13 press with done");
    play_done = 1;
    cyc(1);
    play_done = 0;
    cyc(10);
    check(busy == 1 && play_group == 3, "R13 new group", play_group, 3);
    set_keys(8'd0);
    done_pulse();
    drained("R13 queue");

    // R4 sequential walk
    expect_ev(0, 33, "R4 first seq group");
    btn_pulse();
    btn_pulse();
    check(play_group == 33, "R4 refused press keeps walk", play_group, 33);
    done_pulse();
    for (int g = 34; g <= 254; g++) begin
      expect_ev(0, g, "R4 seq walk");
      btn_pulse();
      done_pulse();
    end
    expect_ev(0, 33, "R4 wrap to 33");
    btn_pulse();
    done_pulse();
    drained("R4 queue");

    // R5 parallel mode
    mode = 2'b01;
    set_keys(8'h88);
    check(busy == 0, "R5 address without strobe", busy, 0);
    expect_ev(0, 137, "R5 address 88h");
    btn_pulse();
    done_pulse();
    set_keys(8'hFE);
    btn_pulse();
    check(busy == 0, "R5 address FEh ignored", busy, 0);
    set_keys(8'hFD);
    expect_ev(0, 254, "R5 address FDh");
    btn_pulse();
    done_pulse();
    set_keys(8'h00);
    expect_ev(0, 1, "R5 address 00h");
    btn_pulse();
    done_pulse();
    drained("R5 queue");

    // R2 disabled modes
    mode = 2'b10;
    set_keys(8'd1);
    btn_pulse();
    set_keys(8'd0);
    mode = 2'b11;
    set_keys(8'd2);
    btn_pulse();
    set_keys(8'd0);
    check(busy == 0, "R2 modes off", busy, 0);
    drained("R2 queue");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule